// File: doc/BRIEF.md
# Word-Parallel Bit-Sliced Pseudo-Random Generator

This block keeps a list of DEPTH words of WIDTH bits each. Bit column c of the list is a DEPTH-stage linear feedback shift register of its own, so WIDTH independent single-bit generators advance together. Each step produces one WIDTH-bit word, and no bit of that word is a shifted copy of the word before it. The list sits in register-file storage with one read port and one write port. A head pointer marks the newest stage. A step reads the newest stage, then reads the tap stage, XORs the two words, and writes the result into the slot just before the head. That slot becomes the new head. No other entry moves, so making the list longer costs storage and no extra cycles.

Software or a neighbouring block loads a seed one stage at a time through the seed port. Stage indices are logical, so index 0 is always the newest stage whatever the head pointer holds. A column that is all zeros would produce zeros for ever. For this reason the block only accepts steps once every column holds at least one 1, and it reports that condition on `seed_ok`. The control is a four-state machine: `ST_IDLE`, `ST_FETCH_HEAD`, `ST_FETCH_TAP` and `ST_COMMIT`. Its transitions are named as follows:
- accept: `ST_IDLE` to `ST_FETCH_HEAD` when a step is requested with `seed_ok` high.
- hold: `ST_IDLE` to itself in every other case.
- read-on: `ST_FETCH_HEAD` to `ST_FETCH_TAP`.
- finish: `ST_FETCH_TAP` to `ST_COMMIT`.
- retire: `ST_COMMIT` to `ST_IDLE`.

Top module: `lfsr_bank`

## Requirements
- R1: In reset and on the first cycle after it, `busy`, `out_valid` and `seed_ok` are 0 and `out_word` is all zeros. Every stage is cleared.
- R2: `seed_ok` is 1 exactly when every one of the WIDTH bit columns holds at least one 1 among the DEPTH stages. It follows a seed write one cycle later.
- R3: A step request made while `seed_ok` is 0 is ignored. `busy` stays 0, no `out_valid` pulse appears, and the stored stages are unchanged.
- R4: Each step yields the word (stage 1 XOR stage TAP), where stage 1 is the newest entry. That word becomes the new stage 1 and every older stage moves one place deeper, so bit c of the sequence follows the single-bit recurrence s[n] = s[n-1] XOR s[n-TAP].
- R5: A request that is accepted in `ST_IDLE` raises `busy` on the next cycle for exactly three cycles. `out_valid` pulses for one cycle with the new word in the cycle in which `busy` falls.
- R6: A step request that arrives while `busy` is 1 is dropped and does not queue a further step.
- R7: A seed write made while `busy` is 1 is ignored.
- R8: A seed write with `seed_addr` = k writes logical stage k+1, where k = 0 is the newest stage, whatever steps have happened before. Addresses of DEPTH or above are ignored.
- R9: Once `seed_ok` is 1, stepping never clears it. With the default parameters, the 31-bit state of column 0 does not return to its starting value within 10000 steps.
- R10: Seed writes that empty any single column drop `seed_ok` to 0 and block steps. A later write that puts a 1 back into that column re-enables stepping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_we | input | 1 | Seed write strobe |
| seed_addr | input | AW = clog2(DEPTH) | Logical stage index, 0 = newest |
| seed_data | input | WIDTH | Seed word for that stage |
| step_req | input | 1 | Request one generator step |
| out_word | output | WIDTH | Most recently generated word |
| out_valid | output | 1 | One-cycle pulse when `out_word` is new |
| busy | output | 1 | Step in progress, requests and seed writes ignored |
| seed_ok | output | 1 | Every bit column holds at least one 1 |

## Verification
The assertions take for granted that `step_req` and `seed_we` are never asserted in the same idle cycle. They also take for granted that a seed write and its effect on `seed_ok` are only judged after the write has landed. The driver keeps to this by issuing seed writes and step requests in separate cycles. It makes deliberate overlaps only while `busy` is high, where both inputs must be ignored. The scoreboard model is a set of WIDTH independent single-bit shift registers. Because the write always goes to the slot before the head, the expected words do not depend on where the head pointer sits.

// File: rtl/lfsr_bank_pkg.sv
package lfsr_bank_pkg;

    // Sequencer states of one generator step.
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_FETCH_HEAD = 2'd1,
        ST_FETCH_TAP  = 2'd2,
        ST_COMMIT     = 2'd3
    } step_state_e;

endpackage

// File: rtl/lfsr_bank_ptr.sv
// Head pointer and address arithmetic for the circular stage list.
module lfsr_bank_ptr #(
    parameter int DEPTH = 31,
    parameter int TAP   = 31,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic [AW-1:0] seed_idx,
    output logic [AW-1:0] head,
    output logic [AW-1:0] tap_addr,
    output logic [AW-1:0] new_head,
    output logic [AW-1:0] seed_phys,
    output logic          seed_in_range
);

    localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);
    localparam logic [AW:0] TAP_OFS = (AW+1)'(TAP - 1);
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

    logic [AW-1:0] head_q;
    logic [AW:0]   tap_sum;
    logic [AW:0]   seed_sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
        end else if (advance) begin
            head_q <= new_head;
        end
    end

    always_comb begin
        new_head = (head_q == '0) ? LAST : head_q - AW'(1);

        tap_sum = {1'b0, head_q} + TAP_OFS;
        if (tap_sum >= DEPTH_W) begin
            tap_sum = tap_sum - DEPTH_W;
        end
        tap_addr = tap_sum[AW-1:0];

        seed_in_range = ({1'b0, seed_idx} < DEPTH_W);
        seed_sum = {1'b0, head_q} + {1'b0, seed_idx};
        if (seed_sum >= DEPTH_W) begin
            seed_sum = seed_sum - DEPTH_W;
        end
        seed_phys = seed_sum[AW-1:0];
    end

    assign head = head_q;

endmodule

// File: rtl/lfsr_bank_store.sv
// Register-file storage of the stage list: one read port, one write port,
// plus a per-column occupancy summary.
module lfsr_bank_store #(
    parameter int DEPTH = 31,
    parameter int WIDTH = 8,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] col_any
);

    logic [WIDTH-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[e] <= '0;
            end else if (we && (waddr == AW'(e))) begin
                mem[e] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (raddr == AW'(e)) begin
                rdata = mem[e];
            end
        end
    end

    always_comb begin
        col_any = '0;
        for (int e = 0; e < DEPTH; e++) begin
            col_any = col_any | mem[e];
        end
    end

endmodule

// File: rtl/lfsr_bank_ctrl.sv
// Step sequencer: idle, fetch newest stage, fetch tap stage, commit.
module lfsr_bank_ctrl
    import lfsr_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        step_req,
    input  logic        seed_ok,
    output step_state_e state,
    output logic        busy,
    output logic        sel_tap,
    output logic        cap_a,
    output logic        cap_b,
    output logic        commit
);

    step_state_e state_q;
    step_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (step_req && seed_ok) state_d = ST_FETCH_HEAD;
            ST_FETCH_HEAD: state_d = ST_FETCH_TAP;
            ST_FETCH_TAP:  state_d = ST_COMMIT;
            ST_COMMIT:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b1;
        sel_tap = 1'b0;
        cap_a   = 1'b0;
        cap_b   = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE:       busy = 1'b0;
            ST_FETCH_HEAD: cap_a = 1'b1;
            ST_FETCH_TAP: begin
                sel_tap = 1'b1;
                cap_b   = 1'b1;
            end
            ST_COMMIT:     commit = 1'b1;
            default:       busy = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/lfsr_bank.sv
// Word-parallel bit-sliced pseudo-random generator, top level.
module lfsr_bank
    import lfsr_bank_pkg::*;
#(
    parameter int DEPTH = 31,
    parameter int WIDTH = 8,
    parameter int TAP   = 31,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seed_we,
    input  logic [AW-1:0]    seed_addr,
    input  logic [WIDTH-1:0] seed_data,
    input  logic             step_req,
    output logic [WIDTH-1:0] out_word,
    output logic             out_valid,
    output logic             busy,
    output logic             seed_ok
);

    step_state_e      state;
    logic             sel_tap;
    logic             cap_a;
    logic             cap_b;
    logic             commit;

    logic [AW-1:0]    head_q;
    logic [AW-1:0]    tap_addr;
    logic [AW-1:0]    new_head;
    logic [AW-1:0]    seed_phys;
    logic             seed_in_range;

    logic             st_we;
    logic [AW-1:0]    st_waddr;
    logic [WIDTH-1:0] st_wdata;
    logic [AW-1:0]    st_raddr;
    logic [WIDTH-1:0] st_rdata;
    logic [WIDTH-1:0] col_any;

    logic [WIDTH-1:0] op_a_q;
    logic [WIDTH-1:0] op_b_q;
    logic [WIDTH-1:0] feedback;
    logic [WIDTH-1:0] out_word_q;
    logic             out_valid_q;
    logic             seed_take;

    lfsr_bank_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .step_req (step_req),
        .seed_ok  (seed_ok),
        .state    (state),
        .busy     (busy),
        .sel_tap  (sel_tap),
        .cap_a    (cap_a),
        .cap_b    (cap_b),
        .commit   (commit)
    );

    lfsr_bank_ptr #(
        .DEPTH (DEPTH),
        .TAP   (TAP),
        .AW    (AW)
    ) u_ptr (
        .clk           (clk),
        .rst           (rst),
        .advance       (commit),
        .seed_idx      (seed_addr),
        .head          (head_q),
        .tap_addr      (tap_addr),
        .new_head      (new_head),
        .seed_phys     (seed_phys),
        .seed_in_range (seed_in_range)
    );

    lfsr_bank_store #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .AW    (AW)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (st_we),
        .waddr   (st_waddr),
        .wdata   (st_wdata),
        .raddr   (st_raddr),
        .rdata   (st_rdata),
        .col_any (col_any)
    );

    assign feedback  = op_a_q ^ op_b_q;
    assign seed_take = seed_we && !busy && seed_in_range;
    assign st_raddr  = sel_tap ? tap_addr : head_q;

    always_comb begin
        if (commit) begin
            st_we    = 1'b1;
            st_waddr = new_head;
            st_wdata = feedback;
        end else begin
            st_we    = seed_take;
            st_waddr = seed_phys;
            st_wdata = seed_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_a_q      <= '0;
            op_b_q      <= '0;
            out_word_q  <= '0;
            out_valid_q <= 1'b0;
        end else begin
            if (cap_a) op_a_q <= st_rdata;
            if (cap_b) op_b_q <= st_rdata;
            out_valid_q <= commit;
            if (commit) out_word_q <= feedback;
        end
    end

    assign seed_ok   = &col_any;
    assign out_word  = out_word_q;
    assign out_valid = out_valid_q;

endmodule

// File: rtl/lfsr_bank_chk.sv
// Temporal checks on the generator, attached by bind.
module lfsr_bank_chk #(
    parameter int DEPTH = 31,
    parameter int AW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          step_req,
    input logic          seed_we,
    input logic          busy,
    input logic          seed_ok,
    input logic          out_valid,
    input logic [AW-1:0] head
);

    a_r3_no_start_unseeded: assert property (@(posedge clk) disable iff (rst)
        (!busy && !seed_ok) |=> !busy);

    a_r5_accept: assert property (@(posedge clk) disable iff (rst)
        (!busy && seed_ok && step_req) |=> busy);

    a_r5_busy_three: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy ##1 busy ##1 !busy);

    a_r5_valid_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> out_valid);

    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r4_head_back_one: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (head == (($past(head) == '0) ? AW'(DEPTH - 1)
                                                      : $past(head) - AW'(1))));

    a_r9_seed_ok_kept: assert property (@(posedge clk) disable iff (rst)
        (seed_ok && !(seed_we && !busy)) |=> seed_ok);

endmodule

bind lfsr_bank lfsr_bank_chk #(
    .DEPTH (DEPTH),
    .AW    (AW)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .step_req  (step_req),
    .seed_we   (seed_we),
    .busy      (busy),
    .seed_ok   (seed_ok),
    .out_valid (out_valid),
    .head      (head_q)
);

// File: tb/lfsr_bank_tb_top.sv
`timescale 1ns/1ps
module lfsr_bank_tb_top;

    localparam int N  = 31;
    localparam int W  = 8;
    localparam int T  = 31;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          seed_we = 1'b0;
    logic [AW-1:0] seed_addr = '0;
    logic [W-1:0]  seed_data = '0;
    logic          step_req = 1'b0;
    logic [W-1:0]  out_word;
    logic          out_valid;
    logic          busy;
    logic          seed_ok;

    int n_checks = 0;
    int n_fails  = 0;
    int n_valids = 0;
    bit done     = 1'b0;

    logic [W-1:0] exp_q [$];
    logic [N-1:0] col [W];   // reference: one single-bit register per column, bit 0 = newest

    always #2.5 clk = ~clk;

    lfsr_bank dut_i (
        .clk       (clk),
        .rst       (rst),
        .seed_we   (seed_we),
        .seed_addr (seed_addr),
        .seed_data (seed_data),
        .step_req  (step_req),
        .out_word  (out_word),
        .out_valid (out_valid),
        .busy      (busy),
        .seed_ok   (seed_ok)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model_step();
        logic [W-1:0] w;
        for (int c = 0; c < W; c++) begin
            w[c]   = col[c][0] ^ col[c][T-1];
            col[c] = {col[c][N-2:0], w[c]};
        end
        return w;
    endfunction

    function automatic logic [W-1:0] model_word(input int idx);
        logic [W-1:0] w;
        for (int c = 0; c < W; c++) w[c] = col[c][idx];
        return w;
    endfunction

    function automatic bit model_ok();
        bit ok = 1'b1;
        for (int c = 0; c < W; c++) if (col[c] == '0) ok = 1'b0;
        return ok;
    endfunction

    // Seed write; the model follows only if the block should take it.
    task automatic seed(input int idx, input logic [W-1:0] data);
        @(negedge clk);
        seed_we   = 1'b1;
        seed_addr = AW'(idx);
        seed_data = data;
        @(negedge clk);
        seed_we = 1'b0;
        if (idx < N) for (int c = 0; c < W; c++) col[c][idx] = data[c];
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_valids++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R6 unexpected out_valid", 32'(out_word), 32'h0);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                check(out_word == e, "R4 word", 32'(out_word), 32'(e));
            end
        end
    end

    task automatic do_step(input bit poke_req, input bit poke_seed);
        exp_q.push_back(model_step());
        @(negedge clk);
        step_req = 1'b1;
        @(negedge clk);
        step_req = 1'b0;
        check(busy == 1'b1, "R5 busy after accept", 32'(busy), 32'h1);
        if (poke_req) step_req = 1'b1;   // R6: must be dropped
        if (poke_seed) begin             // R7: must be ignored
            seed_we   = 1'b1;
            seed_addr = '0;
            seed_data = '0;
        end
        @(negedge clk);
        step_req = 1'b0;
        seed_we  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(out_valid && !busy, "R5 valid as busy falls", {out_valid, busy}, 32'h2);
    endtask

    initial begin
        for (int c = 0; c < W; c++) col[c] = '0;
        repeat (3) @(negedge clk);
        check(!busy && !out_valid && !seed_ok && out_word == '0, "R1 reset",
              {out_word, out_valid, busy, seed_ok}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !out_valid && !seed_ok && out_word == '0, "R1 after reset",
              {out_word, out_valid, busy, seed_ok}, 32'h0);

        // R3: step while unseeded
        step_req = 1'b1;
        repeat (6) begin
            @(negedge clk);
            check(!busy, "R3 busy stays low unseeded", 32'(busy), 32'h0);
        end
        step_req = 1'b0;

        // R8: out-of-range address ignored
        seed(31, 8'hFF);
        @(negedge clk);
        check(!seed_ok, "R8 out-of-range write ignored", 32'(seed_ok), 32'h0);

        // R2: partial then full coverage
        seed(0, 8'h0F);
        check(!seed_ok, "R2 half columns", 32'(seed_ok), 32'h0);
        seed(30, 8'hF0);
        check(seed_ok == model_ok(), "R2 all columns", 32'(seed_ok), 32'h1);
        seed(5, 8'hA5);
        seed(17, 8'h3C);
        seed(29, 8'h81);

        // R4: sequence against the model
        for (int i = 0; i < 40; i++) do_step(1'b0, 1'b0);

        // R6 and R7 overlaps while busy
        do_step(1'b1, 1'b0);
        do_step(1'b0, 1'b1);
        for (int i = 0; i < 8; i++) do_step(1'b0, 1'b0);
        repeat (6) @(negedge clk);
        check(n_valids == 50 && exp_q.size() == 0, "R6 one output per accepted step",
              32'(n_valids), 32'd50);

        // R8: logical addressing after the head has moved
        seed(0, 8'h77);
        seed(30, 8'h12);
        seed(14, 8'hC3);
        for (int i = 0; i < 35; i++) do_step(1'b0, 1'b0);

        // R10: empty column 7, steps blocked, then restore
        for (int i = 0; i < N; i++) seed(i, model_word(i) & 8'h7F);
        check(!seed_ok, "R10 column 7 emptied", 32'(seed_ok), 32'h0);
        step_req = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(!busy, "R10 step blocked", 32'(busy), 32'h0);
        end
        step_req = 1'b0;
        seed(9, model_word(9) | 8'h80);
        check(seed_ok, "R10 column restored", 32'(seed_ok), 32'h1);
        for (int i = 0; i < 20; i++) do_step(1'b0, 1'b0);

        // R9: long run, column 0 must not revisit its start state
        begin
            logic [N-1:0] start0;
            bit           rep = 1'b0;
            bit           lost = 1'b0;
            start0 = col[0];
            for (int i = 0; i < 10000; i++) begin
                do_step(1'b0, 1'b0);
                if (col[0] == start0) rep = 1'b1;
                if (!seed_ok) lost = 1'b1;
            end
            check(!rep, "R9 column 0 no repeat in 10000", 32'(rep), 32'h0);
            check(!lost, "R9 seed_ok held", 32'(lost), 32'h0);
        end

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4 scoreboard drained", 32'(exp_q.size()), 32'h0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule